// File: doc/BRIEF.md
# Holdover Offset Selector

This block produces the frequency offset command that a timing generator passes to its slew limiter. Every offset is expressed in 0.1 ppm units relative to nominal. The command always starts from the calibrated freerun point, which is a signed calibration word. A mode input from an outside controller picks what is added on top of that point:

- In freerun, nothing is added.
- In holdover, one of two history values is added: the history the device accumulated itself, or a value that software supplied.
- In synchronized operation, the measured reference offset is added.

Synchronized operation has two special cases:

- When the reference signal is lost, the short-term history is used in place of the reference offset.
- When the reference offset is larger in magnitude than a programmed pull-in range, a policy bit chooses between two outcomes. The command either saturates at the range edge on the side of the reference's sign, or follows the reference anyway.

A registered flag reports the out-of-range condition. A registered copy of the short-term history lets software read it and build its own history. Filtering of the histories happens elsewhere. All outputs are registered, one cycle after the inputs.

Top module: `hos_offset_sel`

## Requirements
- R1: While `rst` is high, and on the first edge after it rises, `off_cmd_o`, `oor_o` and `st_rd_o` are all zero.
- R2: With `mode_i` = 2'b00 (freerun), `off_cmd_o` equals the sign-extended `cal_i` one clock after the inputs. All other offset inputs are ignored.
- R3: `mode_i` = 2'b11 is reserved and behaves exactly like freerun.
- R4: With `mode_i` = 2'b01 (holdover) and `ho_user_i` = 0, `off_cmd_o` = `cal_i` + `dev_hist_i`, one clock later.
- R5: With `mode_i` = 2'b01 and `ho_user_i` = 1, `off_cmd_o` = `cal_i` + `user_hist_i`, one clock later.
- R6: With `mode_i` = 2'b10 (synchronized) and `ref_lost_i` = 1, `off_cmd_o` = `cal_i` + `st_hist_i`, whatever the reference offset is.
- R7: With `mode_i` = 2'b10, `ref_lost_i` = 0 and |`ref_off_i`| <= `pir_lim_i`, `off_cmd_o` = `cal_i` + `ref_off_i`. A magnitude equal to the limit counts as in range.
- R8: With `mode_i` = 2'b10, `ref_lost_i` = 0, |`ref_off_i`| > `pir_lim_i` and `oop_follow_i` = 0, the output saturates:
  - `off_cmd_o` = `cal_i` + `pir_lim_i` when `ref_off_i` is positive.
  - `off_cmd_o` = `cal_i` - `pir_lim_i` when `ref_off_i` is negative.
- R9: Under the same out-of-range condition with `oop_follow_i` = 1, `off_cmd_o` = `cal_i` + `ref_off_i`.
- R10: `oor_o` is 1 one clock after a cycle with `mode_i` = 2'b10, `ref_lost_i` = 0 and |`ref_off_i`| > `pir_lim_i`, whatever `oop_follow_i` is. Otherwise `oor_o` is 0.
- R11: In every mode, `st_rd_o` equals `st_hist_i` from the previous clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | 00 freerun, 01 holdover, 10 synchronized, 11 reserved (freerun) |
| ho_user_i | input | 1 | Holdover source: 0 device history, 1 user history |
| oop_follow_i | input | 1 | Out-of-range policy: 0 saturate, 1 follow |
| cal_i | input | CW (11) | Signed freerun calibration, 0.1 ppm units |
| dev_hist_i | input | HW (16) | Signed device-accumulated history |
| user_hist_i | input | HW (16) | Signed software-supplied history |
| st_hist_i | input | HW (16) | Signed short-term history |
| ref_off_i | input | HW (16) | Signed measured reference offset, relative to the freerun point |
| ref_lost_i | input | 1 | Active reference signal lost |
| pir_lim_i | input | HW-1 (15) | Unsigned pull-in range magnitude |
| off_cmd_o | output | HW+1 (17) | Signed offset command to the slew limiter |
| oor_o | output | 1 | Reference beyond pull-in range |
| st_rd_o | output | HW (16) | Short-term history readback |

## Verification
The bench pushes the range test to its edges. It sets a magnitude exactly equal to the limit, which a strict-versus-inclusive mix-up would wrongly saturate. It also drives the most negative reference code, which breaks a naive two's-complement magnitude. It saturates on both signs, because a design that ignores the sign would clamp negative offsets to the positive edge. Extreme calibration and history values check that the sum is widened and cannot wrap. Other cases put a huge reference offset on the bus while the signal is lost or the mode is not synchronized. In those cases the flag must stay low and the offset must not leak into the command.

// File: rtl/hos_pkg.sv
package hos_pkg;
  typedef enum logic [1:0] {
    HOS_FREERUN  = 2'b00,
    HOS_HOLDOVER = 2'b01,
    HOS_SYNC     = 2'b10,
    HOS_RSVD     = 2'b11
  } hos_mode_e;
endpackage

// File: rtl/hos_pir_clamp.sv
// Pull-in range check and saturate-or-follow policy on the reference offset.
module hos_pir_clamp #(
  parameter int HW = 16
) (
  input  logic signed [HW-1:0] ref_off_i,
  input  logic        [HW-2:0] lim_i,
  input  logic                 follow_i,
  output logic                 exceed_o,
  output logic signed [HW-1:0] rel_o
);
  localparam int LW = HW - 1;

  logic [HW-1:0] mag;
  logic [HW-1:0] lim_x;

  // Unsigned magnitude; the most negative code maps to 2^(HW-1) correctly.
  assign mag   = ref_off_i[HW-1] ? (~ref_off_i + 1'b1) : ref_off_i;
  assign lim_x = {1'b0, lim_i[LW-1:0]};

  always_comb begin
    exceed_o = (mag > lim_x);
    if (!exceed_o || follow_i) begin
      rel_o = ref_off_i;
    end else if (ref_off_i[HW-1]) begin
      rel_o = -$signed(lim_x);
    end else begin
      rel_o = $signed(lim_x);
    end
  end
endmodule

// File: rtl/hos_src_mux.sv
// Picks the offset added to the calibrated freerun point.
module hos_src_mux #(
  parameter int HW = 16
) (
  input  logic [1:0]           mode_i,
  input  logic                 ho_user_i,
  input  logic                 lost_i,
  input  logic signed [HW-1:0] dev_i,
  input  logic signed [HW-1:0] usr_i,
  input  logic signed [HW-1:0] st_i,
  input  logic signed [HW-1:0] pir_rel_i,
  output logic signed [HW-1:0] rel_o
);
  import hos_pkg::*;

  always_comb begin
    unique case (hos_mode_e'(mode_i))
      HOS_HOLDOVER: rel_o = ho_user_i ? usr_i : dev_i;
      HOS_SYNC:     rel_o = lost_i ? st_i : pir_rel_i;
      default:      rel_o = '0;
    endcase
  end
endmodule

// File: rtl/hos_offset_sel.sv
module hos_offset_sel #(
  parameter int CW = 11,
  parameter int HW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [1:0]           mode_i,
  input  logic                 ho_user_i,
  input  logic                 oop_follow_i,
  input  logic signed [CW-1:0] cal_i,
  input  logic signed [HW-1:0] dev_hist_i,
  input  logic signed [HW-1:0] user_hist_i,
  input  logic signed [HW-1:0] st_hist_i,
  input  logic signed [HW-1:0] ref_off_i,
  input  logic                 ref_lost_i,
  input  logic [HW-2:0]        pir_lim_i,
  output logic signed [HW:0]   off_cmd_o,
  output logic                 oor_o,
  output logic signed [HW-1:0] st_rd_o
);
  import hos_pkg::*;

  localparam int OW = HW + 1;

  logic                 exceed;
  logic signed [HW-1:0] pir_rel;
  logic signed [HW-1:0] rel;
  logic signed [OW-1:0] cal_x;
  logic signed [OW-1:0] rel_x;
  logic                 oor_nx;

  hos_pir_clamp #(.HW(HW)) u_clamp (
    .ref_off_i (ref_off_i),
    .lim_i     (pir_lim_i),
    .follow_i  (oop_follow_i),
    .exceed_o  (exceed),
    .rel_o     (pir_rel)
  );

  hos_src_mux #(.HW(HW)) u_mux (
    .mode_i    (mode_i),
    .ho_user_i (ho_user_i),
    .lost_i    (ref_lost_i),
    .dev_i     (dev_hist_i),
    .usr_i     (user_hist_i),
    .st_i      (st_hist_i),
    .pir_rel_i (pir_rel),
    .rel_o     (rel)
  );

  assign cal_x  = {{(OW-CW){cal_i[CW-1]}}, cal_i};
  assign rel_x  = {rel[HW-1], rel};
  assign oor_nx = exceed && !ref_lost_i && (mode_i == HOS_SYNC);

  always_ff @(posedge clk) begin
    if (rst) begin
      off_cmd_o <= '0;
      oor_o     <= 1'b0;
      st_rd_o   <= '0;
    end else begin
      off_cmd_o <= cal_x + rel_x;
      oor_o     <= oor_nx;
      st_rd_o   <= st_hist_i;
    end
  end
endmodule

// File: rtl/hos_offset_sel_chk.sv
module hos_offset_sel_chk #(
  parameter int CW = 11,
  parameter int HW = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic [1:0]           mode_i,
  input logic                 oop_follow_i,
  input logic signed [CW-1:0] cal_i,
  input logic signed [HW-1:0] st_hist_i,
  input logic signed [HW-1:0] ref_off_i,
  input logic                 ref_lost_i,
  input logic [HW-2:0]        pir_lim_i,
  input logic signed [HW:0]   off_cmd_o,
  input logic                 oor_o,
  input logic signed [HW-1:0] st_rd_o
);
  logic                 pv;
  logic signed [HW+1:0] cal_p;
  logic signed [HW+1:0] diff;

  always_ff @(posedge clk) begin
    if (rst) pv <= 1'b0;
    else     pv <= 1'b1;
  end

  always_ff @(posedge clk) cal_p <= {{(HW+2-CW){cal_i[CW-1]}}, cal_i};
  assign diff = {off_cmd_o[HW], off_cmd_o} - cal_p;

  p_reset_r1: assert property (@(posedge clk) $past(rst) |-> (off_cmd_o == '0 && !oor_o && st_rd_o == '0));

  p_freerun_r2: assert property (@(posedge clk) disable iff (rst)
    pv && $past(mode_i) == 2'b00 |-> diff == '0);

  p_reserved_r3: assert property (@(posedge clk) disable iff (rst)
    pv && $past(mode_i) == 2'b11 |-> diff == '0);

  p_lost_r6: assert property (@(posedge clk) disable iff (rst)
    pv && $past(mode_i) == 2'b10 && $past(ref_lost_i) |-> diff == $past(st_hist_i));

  p_sat_r8: assert property (@(posedge clk) disable iff (rst)
    pv && oor_o && !$past(oop_follow_i) |->
      ((diff[HW+1] ? -diff : diff) == $past(pir_lim_i)) && (diff[HW+1] == $past(ref_off_i[HW-1])));

  p_follow_r9: assert property (@(posedge clk) disable iff (rst)
    pv && oor_o && $past(oop_follow_i) |-> diff == $past(ref_off_i));

  p_flag_r10: assert property (@(posedge clk) disable iff (rst)
    pv && oor_o |-> $past(mode_i) == 2'b10 && !$past(ref_lost_i));

  p_readback_r11: assert property (@(posedge clk) disable iff (rst)
    pv |-> st_rd_o == $past(st_hist_i));
endmodule

bind hos_offset_sel hos_offset_sel_chk #(.CW(CW), .HW(HW)) u_chk (
  .clk(clk), .rst(rst), .mode_i(mode_i), .oop_follow_i(oop_follow_i),
  .cal_i(cal_i), .st_hist_i(st_hist_i), .ref_off_i(ref_off_i),
  .ref_lost_i(ref_lost_i), .pir_lim_i(pir_lim_i), .off_cmd_o(off_cmd_o),
  .oor_o(oor_o), .st_rd_o(st_rd_o)
);

// File: tb/tb_hos_offset_sel.sv
`timescale 1ns/1ps
module tb_hos_offset_sel;
  localparam int CW = 11;
  localparam int HW = 16;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic [1:0]           mode_i = '0;
  logic                 ho_user_i = 1'b0;
  logic                 oop_follow_i = 1'b0;
  logic signed [CW-1:0] cal_i = '0;
  logic signed [HW-1:0] dev_hist_i = '0;
  logic signed [HW-1:0] user_hist_i = '0;
  logic signed [HW-1:0] st_hist_i = '0;
  logic signed [HW-1:0] ref_off_i = '0;
  logic                 ref_lost_i = 1'b0;
  logic [HW-2:0]        pir_lim_i = '0;
  logic signed [HW:0]   off_cmd_o;
  logic                 oor_o;
  logic signed [HW-1:0] st_rd_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  typedef struct {
    int    off;
    bit    oor;
    int    st;
    string req;
  } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  hos_offset_sel #(.CW(CW), .HW(HW)) dut (
    .clk(clk), .rst(rst), .mode_i(mode_i), .ho_user_i(ho_user_i),
    .oop_follow_i(oop_follow_i), .cal_i(cal_i), .dev_hist_i(dev_hist_i),
    .user_hist_i(user_hist_i), .st_hist_i(st_hist_i), .ref_off_i(ref_off_i),
    .ref_lost_i(ref_lost_i), .pir_lim_i(pir_lim_i), .off_cmd_o(off_cmd_o),
    .oor_o(oor_o), .st_rd_o(st_rd_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Driver: apply one input set at the falling edge and queue its expectation.
  task automatic drive(input string req, input int m, input bit hu, input bit fol,
                       input int cal, input int dev, input int usr, input int st,
                       input int rf, input bit lost, input int lim);
    exp_t e;
    int rel;
    int mag;
    @(negedge clk);
    mode_i = 2'(m); ho_user_i = hu; oop_follow_i = fol;
    cal_i = CW'(cal); dev_hist_i = HW'(dev); user_hist_i = HW'(usr);
    st_hist_i = HW'(st); ref_off_i = HW'(rf); ref_lost_i = lost;
    pir_lim_i = (HW-1)'(lim);
    mag = (rf < 0) ? -rf : rf;
    e.oor = 1'b0;
    case (m)
      1: rel = hu ? usr : dev;
      2: begin
        if (lost) rel = st;
        else if (mag > lim) begin
          e.oor = 1'b1;
          rel = fol ? rf : ((rf < 0) ? -lim : lim);
        end else rel = rf;
      end
      default: rel = 0;
    endcase
    e.off = cal + rel;
    e.st  = st;
    e.req = req;
    sb.push_back(e);
  endtask

  // Monitor: compare just after the edge that registers the queued inputs.
  always @(posedge clk) begin
    #1;
    if (!rst && sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check({e.req, " offset"}, int'(off_cmd_o), e.off);
      check({e.req, " flag R10"}, int'(oor_o), int'(e.oor));
      check({e.req, " readback R11"}, int'(st_rd_o), e.st);
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset offset", int'(off_cmd_o), 0);
    check("R1 reset flag", int'(oor_o), 0);
    check("R1 reset readback", int'(st_rd_o), 0);
    @(negedge clk); rst = 1'b0;

    // m, hu, fol, cal, dev, usr, st, ref, lost, lim
    drive("R2 freerun max cal", 0, 0, 0, 1023, 500, -7, 12, 30000, 0, 10);
    drive("R2 freerun min cal", 0, 1, 1, -1024, -9000, 9000, -3, -32768, 0, 0);
    drive("R3 reserved mode", 3, 1, 0, 77, 1234, 4321, 55, 20000, 0, 5);
    drive("R4 holdover device", 1, 0, 0, 1023, 32767, -5, 1, 0, 0, 0);
    drive("R4 holdover device neg", 1, 0, 1, -1024, -32768, 100, 2, 0, 0, 0);
    drive("R5 holdover user", 1, 1, 0, -300, 999, 32767, 3, -32000, 0, 1);
    drive("R6 lost ref", 2, 0, 0, 250, 1, 2, -1500, -32768, 1, 10);
    drive("R6 lost ref follow", 2, 1, 1, -250, 1, 2, 32767, 32767, 1, 0);
    drive("R7 in range", 2, 0, 0, 40, 0, 0, 9, -1999, 0, 2000);
    drive("R7 at limit", 2, 0, 0, -40, 0, 0, 8, 2000, 0, 2000);
    drive("R7 at neg limit", 2, 0, 0, 5, 0, 0, 7, -2000, 0, 2000);
    drive("R8 saturate pos", 2, 0, 0, 100, 0, 0, 6, 2001, 0, 2000);
    drive("R8 saturate neg", 2, 1, 0, -100, 0, 0, 5, -25000, 0, 2000);
    drive("R8 most negative code", 2, 0, 0, 1023, 0, 0, 4, -32768, 0, 32767);
    drive("R8 zero limit", 2, 0, 0, 0, 0, 0, 3, 1, 0, 0);
    drive("R9 follow pos", 2, 0, 1, 1023, 0, 0, 2, 32767, 0, 100);
    drive("R9 follow neg", 2, 0, 1, -1024, 0, 0, 1, -32768, 0, 100);
    drive("R10 holdover no flag", 1, 0, 0, 0, 10, 20, 0, 32767, 0, 0);
    drive("R11 readback neg", 0, 0, 0, 0, 0, 0, -32768, 0, 0, 0);
    drive("R11 readback pos", 2, 0, 0, 0, 0, 0, 32767, 0, 0, 0);

    @(negedge clk);
    rst = 1'b1;
    @(posedge clk); #1;
    check("R1 mid-run reset offset", int'(off_cmd_o), 0);
    check("R1 mid-run reset flag", int'(oor_o), 0);
    check("R1 mid-run reset readback", int'(st_rd_o), 0);
    @(negedge clk); rst = 1'b0;
    drive("R2 after reset", 0, 0, 0, -1, 0, 0, 0, 0, 0, 0);
    repeat (3) @(posedge clk);
    #2;
    check("R2 scoreboard drained", sb.size(), 0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule